// File: doc/BRIEF.md
# Multi-Phase Shift-Register Timing Generator

This block divides a system clock into a repeating set of phase enables. Each phase enable is high for one clock and no two are ever high together. A circulating shift register with feedback holds the state. An elaboration parameter selects one of two shapes for that register:

- **Ring.** STAGES flip-flops pass a single set bit around the loop, which gives STAGES phases taken straight from the flops.
- **Twisted.** The inverted top stage feeds the bottom stage, so STAGES flip-flops give 2*STAGES phases. Each phase is the AND of two bits.

Both shapes watch their own state. Any pattern outside the legal cycle is replaced by the start pattern on the next clock. While the state is illegal, all phase outputs are held low, so no stray enable reaches the logic downstream.

The phase vector is meant to drive enables in a design clocked on the same edge. Phases are decoded only from registered state, so the inputs have no combinational path to the outputs. Reset is synchronous and active high. The enable input pauses the sequence. STAGES must be 2 or more. There is no data stream at this boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `phase_seq_gen`

## Requirements
- R1: When `rst` is high at a rising edge, the next output has only `phase_o[0]` high. Reset takes priority over `en`.
- R2: In ring mode (MODE = MODE_RING, encoding 0) there are STAGES phases. Each rising edge with `en` high and `rst` low moves the high bit from index k to index k+1, and from STAGES-1 back to 0.
- R3: In twisted mode (MODE = MODE_TWISTED, encoding 1) there are 2*STAGES phases. They advance by one index per enabled edge in the same way, wrapping from 2*STAGES-1 to 0. Each phase is a two-input AND of state bits.
- R4: A rising edge with `en` low and `rst` low leaves `phase_o` unchanged.
- R5: At most one bit of `phase_o` is high in any cycle. Exactly one is high whenever the state is legal.
- R6: In ring mode, a state that is not one-hot (this includes all-zero) becomes the start pattern at the next rising edge, whatever the level of `en`. The output then has phase 0 high.
- R7: In twisted mode, a state that is not one of the 2*STAGES legal codes becomes all-zero at the next rising edge, whatever the level of `en`. The output then has phase 0 high.
- R8: While the state is illegal, every bit of `phase_o` is low.
- R9: `phase_o` depends only on registered state. A change of `en` or `rst` between clock edges does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the start pattern |
| en | input | 1 | Advance enable; when low, the sequence holds |
| phase_o | output | PHASES | One-hot phase enables; PHASES is STAGES in ring mode and 2*STAGES in twisted mode |

## Verification
An internal state that is wrong but legal shows up at the ports on the next enabled edge. The phase index either jumps by more than one or fails to wrap, and the one-step rotation check catches this. An illegal state shows up at once, within the same cycle, as an all-low phase vector. One clock later the port must show phase 0 alone. If it does not, either the correction logic or the output masking has failed. The bench pushes both shapes into several illegal patterns, with the enable both low and high, and checks the cycle of blanking and then the restart.

// File: rtl/phase_gen_pkg.sv
package phase_gen_pkg;

  // Shape of the feedback loop
  typedef enum logic {
    MODE_RING    = 1'b0,  // single circulating one
    MODE_TWISTED = 1'b1   // inverted top stage fed back
  } seq_mode_e;

  // Number of phase outputs produced by a loop of the given length
  function automatic int phase_count(input seq_mode_e mode, input int stages);
    return (mode == MODE_TWISTED) ? 2 * stages : stages;
  endfunction

endpackage

// File: rtl/phase_state_check.sv
// Decides whether the loop state belongs to the legal cycle.
module phase_state_check #(
  parameter int                      STAGES = 4,
  parameter phase_gen_pkg::seq_mode_e MODE  = phase_gen_pkg::MODE_RING
) (
  input  logic [STAGES-1:0] state_i,
  output logic              legal_o
);
  import phase_gen_pkg::*;

  localparam int EDGES = STAGES - 1;

  generate
    if (MODE == MODE_RING) begin : g_ring
      // Legal: exactly one bit set
      logic any_set;
      logic many_set;
      always_comb begin
        any_set  = 1'b0;
        many_set = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
          many_set = many_set | (any_set & state_i[i]);
          any_set  = any_set | state_i[i];
        end
      end
      assign legal_o = any_set & ~many_set;
    end else begin : g_twisted
      // Legal: the bits form one run of ones and one run of zeros,
      // so at most one neighbour pair differs
      logic [EDGES-1:0] diff;
      logic             seen;
      logic             extra;
      assign diff = state_i[STAGES-1:1] ^ state_i[STAGES-2:0];
      always_comb begin
        seen  = 1'b0;
        extra = 1'b0;
        for (int i = 0; i < EDGES; i++) begin
          extra = extra | (seen & diff[i]);
          seen  = seen | diff[i];
        end
      end
      assign legal_o = ~extra;
    end
  endgenerate

endmodule

// File: rtl/phase_state_reg.sv
// Loop register: reset, self-correction and the enabled shift.
module phase_state_reg #(
  parameter int                      STAGES = 4,
  parameter phase_gen_pkg::seq_mode_e MODE  = phase_gen_pkg::MODE_RING
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              legal_i,
  output logic [STAGES-1:0] state_o
);
  import phase_gen_pkg::*;

  localparam logic [STAGES-1:0] START =
    (MODE == MODE_RING) ? {{(STAGES-1){1'b0}}, 1'b1} : {STAGES{1'b0}};

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] shifted;
  logic              feed;

  generate
    if (MODE == MODE_RING) begin : g_ring_feed
      assign feed = state_q[STAGES-1];
    end else begin : g_twisted_feed
      assign feed = ~state_q[STAGES-1];
    end
  endgenerate

  assign shifted = {state_q[STAGES-2:0], feed};

  // Correction does not wait for the enable
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= START;
    end else if (!legal_i) begin
      state_q <= START;
    end else if (en) begin
      state_q <= shifted;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/phase_decode.sv
// Turns the registered loop state into phase enables.
module phase_decode #(
  parameter int                      STAGES = 4,
  parameter phase_gen_pkg::seq_mode_e MODE  = phase_gen_pkg::MODE_RING,
  localparam int                     PHASES = phase_gen_pkg::phase_count(MODE, STAGES)
) (
  input  logic [STAGES-1:0] state_i,
  input  logic              legal_i,
  output logic [PHASES-1:0] phase_o
);
  import phase_gen_pkg::*;

  logic [PHASES-1:0] raw;

  generate
    if (MODE == MODE_RING) begin : g_ring_dec
      assign raw = state_i;
    end else begin : g_twisted_dec
      for (genvar k = 0; k < PHASES; k++) begin : g_pair
        if (k == 0) begin : g_all_low
          assign raw[k] = ~state_i[0] & ~state_i[STAGES-1];
        end else if (k < STAGES) begin : g_fill_front
          assign raw[k] = state_i[k-1] & ~state_i[k];
        end else if (k == STAGES) begin : g_all_high
          assign raw[k] = state_i[0] & state_i[STAGES-1];
        end else begin : g_drain_front
          assign raw[k] = ~state_i[k-STAGES-1] & state_i[k-STAGES];
        end
      end
    end
  endgenerate

  // Blank every enable while the loop holds an upset pattern
  assign phase_o = raw & {PHASES{legal_i}};

endmodule

// File: rtl/phase_seq_gen.sv
module phase_seq_gen #(
  parameter int                      STAGES = 4,
  parameter phase_gen_pkg::seq_mode_e MODE  = phase_gen_pkg::MODE_RING,
  localparam int                     PHASES = phase_gen_pkg::phase_count(MODE, STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [PHASES-1:0] phase_o
);

  logic [STAGES-1:0] state;
  logic              legal;

  phase_state_check #(.STAGES(STAGES), .MODE(MODE)) u_check (
    .state_i (state),
    .legal_o (legal)
  );

  phase_state_reg #(.STAGES(STAGES), .MODE(MODE)) u_state (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .legal_i (legal),
    .state_o (state)
  );

  phase_decode #(.STAGES(STAGES), .MODE(MODE)) u_decode (
    .state_i (state),
    .legal_i (legal),
    .phase_o (phase_o)
  );

endmodule

// File: rtl/phase_seq_gen_chk.sv
// Port-level properties of the timing generator.
module phase_seq_gen_chk #(
  parameter int PHASES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [PHASES-1:0] phase_o
);

  localparam logic [PHASES-1:0] FIRST = {{(PHASES-1){1'b0}}, 1'b1};

  // An all-low vector marks an upset state. p_recover_r6 covers the
  // cycle that follows it, so the other properties accept it too.

  p_reset_start_r1: assert property (@(posedge clk)
    rst |=> (phase_o == FIRST) || (phase_o == '0));

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (en && $onehot(phase_o)) |=>
      (phase_o == {$past(phase_o[PHASES-2:0]), $past(phase_o[PHASES-1])}) ||
      (phase_o == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && $onehot(phase_o)) |=> $stable(phase_o) || (phase_o == '0));

  p_at_most_one_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase_o));

  // R7 shares this property in twisted mode
  p_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_o == '0) |=> (phase_o == FIRST));

endmodule

bind phase_seq_gen phase_seq_gen_chk #(.PHASES(PHASES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .phase_o (phase_o)
);

// File: tb/phase_seq_gen_tb.sv
`timescale 1ns/1ps
module phase_seq_gen_tb;
  import phase_gen_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] ph_r;
  logic [7:0] ph_j;
  logic [3:0] bad_r;
  logic [3:0] bad_j;
  int         n_run  = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  phase_seq_gen #(.STAGES(4), .MODE(MODE_RING)) u_dut (
    .clk (clk), .rst (rst), .en (en), .phase_o (ph_r));

  phase_seq_gen #(.STAGES(4), .MODE(MODE_TWISTED)) u_dut_jc (
    .clk (clk), .rst (rst), .en (en), .phase_o (ph_j));

  // {rst, en, expected ring phases, expected twisted phases}
  localparam logic [13:0] VEC [0:13] = '{
    {2'b10, 4'h1, 8'h01},  // reset state
    {2'b01, 4'h2, 8'h02},
    {2'b01, 4'h4, 8'h04},
    {2'b00, 4'h4, 8'h04},  // hold
    {2'b01, 4'h8, 8'h08},
    {2'b01, 4'h1, 8'h10},  // ring wraps
    {2'b01, 4'h2, 8'h20},
    {2'b00, 4'h2, 8'h20},  // hold
    {2'b01, 4'h4, 8'h40},
    {2'b01, 4'h8, 8'h80},
    {2'b01, 4'h1, 8'h01},  // twisted wraps
    {2'b11, 4'h1, 8'h01},  // reset beats enable
    {2'b01, 4'h2, 8'h02},
    {2'b10, 4'h1, 8'h01}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Put both loops into illegal patterns, then watch blanking and restart
  task automatic upset(input logic [3:0] r_bad, input logic [3:0] j_bad, input logic en_val);
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    @(negedge clk);
    bad_r = r_bad;
    bad_j = j_bad;
    force u_dut.u_state.state_q = bad_r;
    force u_dut_jc.u_state.state_q = bad_j;
    #0.5;
    release u_dut.u_state.state_q;
    release u_dut_jc.u_state.state_q;
    rst = 1'b0;
    en  = en_val;
    #0.5;
    check("R8 ring blanked while illegal", {4'h0, ph_r}, 8'h00);
    check("R8 twisted blanked while illegal", ph_j, 8'h00);
    @(posedge clk);
    #1;
    check("R6 ring corrected to phase 0", {4'h0, ph_r}, 8'h01);
    check("R7 twisted corrected to phase 0", ph_j, 8'h01);
    @(negedge clk);
    en = 1'b1;
    @(posedge clk);
    #1;
    check("R2 ring runs after correction", {4'h0, ph_r}, 8'h02);
    check("R3 twisted runs after correction", ph_j, 8'h02);
  endtask

  initial begin
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      rst = VEC[i][13];
      en  = VEC[i][12];
      @(posedge clk);
      #1;
      check($sformatf("R1/R2/R4 ring step %0d", i), {4'h0, ph_r}, {4'h0, VEC[i][11:8]});
      check($sformatf("R1/R3/R4 twisted step %0d", i), ph_j, VEC[i][7:0]);
      check($sformatf("R5 twisted single phase step %0d", i), 8'($countones(ph_j)), 8'd1);
    end

    // R9: input changes between edges leave the outputs alone
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b1;
    #1;
    check("R9 ring unchanged mid-cycle", {4'h0, ph_r}, 8'h01);
    check("R9 twisted unchanged mid-cycle", ph_j, 8'h01);
    @(posedge clk);
    #1;
    check("R2 ring advances after release", {4'h0, ph_r}, 8'h02);
    check("R3 twisted advances after release", ph_j, 8'h02);

    upset(4'b0110, 4'b0101, 1'b0);
    upset(4'b0000, 4'b1011, 1'b1);
    upset(4'b1111, 4'b0100, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule